// File: doc/BRIEF.md
# Rolling Four-Activate Window Limiter

This block enforces a power limit on one DRAM rank. It allows at most four row activates in any run of `WINDOW` consecutive memory-bus cycles. A memory controller creates one instance per rank. It pulses `act_i` for every activate it sends to that rank, whether the activate comes from a normal access or from a refresh. It reads `act_ok_o` before it schedules the next activate for the rank.

Inside the block, a history register `WINDOW` bits wide marks the cycles in which recent activates happened. The marks move one place toward bit 0 on every clock. A counter tracks how many marks are present: it goes up when a mark enters and down when a mark leaves through bit 0. The allow flag comes from that registered count alone, so the flag has no combinational path from `act_i`. When `WINDOW` is 0 the limiter is bypassed. `WINDOW` may range from 0 to 62.

Top module: `faw_limiter`

## Requirements
- R1: After reset, the history and the count are empty and `act_ok_o` is 1.
- R2: An activate sampled on clock edge k stays counted in the states that follow edges k to k+WINDOW-1. The edge k+WINDOW removes it.
- R3: `act_ok_o` is 0 exactly when four or more activates are counted. Four activates on back-to-back edges k..k+3 hold the flag low from edge k+3 up to edge k+WINDOW, and the flag returns to 1 after edge k+WINDOW.
- R4: If an activate arrives on the same edge that an old activate leaves, the history shifts first and the new mark is then placed in the top position, so the count does not change.
- R5: Every `act_i` pulse is recorded, including pulses given while `act_ok_o` is 0. The flag stays low until the count falls below four.
- R6: With `WINDOW` = 0, `act_ok_o` is always 1, whatever `act_i` does.
- R7: The count never exceeds `WINDOW` and always equals the number of marks in the history. When activates stop after a continuous run longer than `WINDOW`, `act_ok_o` returns to 1 after WINDOW-3 idle edges.
- R8: If activates are spaced evenly, the flag depends only on how many of them fall inside the last `WINDOW` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | One-cycle pulse per activate or refresh sent to this rank |
| act_ok_o | output | 1 | 1 when the rank may take another activate |

## Verification
Every cycle, the assertions check the following: the history population matches the count, the count stays within bounds, a leaving mark lowers the count by one, a simultaneous arrival and departure leaves the count unchanged, and a low flag always means four marks are present. Only the bench scenarios can show the exact timing: the edge where the flag reopens after a burst, after a swap and after a saturating run. A scoreboard model built from activate times predicts that flag for every cycle. The bench also runs the bypass instance to show that the flag never drops.

// File: rtl/faw_pkg.sv
package faw_pkg;
    localparam int unsigned FAW_ACTS       = 4;
    localparam int unsigned FAW_MAX_WINDOW = 62;

    function automatic int unsigned faw_cnt_width(input int unsigned window);
        return (window < 1) ? 1 : $clog2(window + 1);
    endfunction
endpackage

// File: rtl/faw_history.sv
module faw_history #(
    parameter int unsigned WINDOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    output logic [WINDOW-1:0] hist_o,
    output logic              expire_o
);
    typedef struct packed {
        logic [WINDOW-1:0] hist;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // age first, then place the new mark at the top
        st_d.hist = st_q.hist >> 1;
        if (act_i) begin
            st_d.hist[WINDOW-1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o   = st_q.hist;
    assign expire_o = st_q.hist[0];

    AST_ACT_ENTERS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> hist_o[WINDOW-1]); // R2
endmodule

// File: rtl/faw_counter.sv
module faw_counter
    import faw_pkg::*;
#(
    parameter int unsigned WINDOW = 16,
    parameter int unsigned CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_i,
    input  logic          expire_i,
    output logic [CW-1:0] cnt_o,
    output logic          ok_o
);
    localparam int unsigned LIMIT = FAW_ACTS;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case ({act_i, expire_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ok_o  = (32'(st_q.cnt) < LIMIT);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_o) <= WINDOW); // R7
endmodule

// File: rtl/faw_limiter.sv
module faw_limiter
    import faw_pkg::*;
#(
    parameter int unsigned WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic act_ok_o
);
    localparam int unsigned CW = faw_cnt_width(WINDOW);

    generate
        if (WINDOW == 0) begin : g_bypass
            assign act_ok_o = 1'b1;
        end else begin : g_limit
            logic [WINDOW-1:0] hist_w;
            logic              expire_w;
            logic [CW-1:0]     cnt_w;

            faw_history #(.WINDOW(WINDOW)) u_hist (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (act_i),
                .hist_o   (hist_w),
                .expire_o (expire_w)
            );

            faw_counter #(.WINDOW(WINDOW), .CW(CW)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_i    (act_i),
                .expire_i (expire_w),
                .cnt_o    (cnt_w),
                .ok_o     (act_ok_o)
            );

            AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(hist_w) == 32'(cnt_w)); // R7
            AST_RETIRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_w[0] && !act_i) |=> (32'(cnt_w) + 1 == 32'($past(cnt_w)))); // R2
            AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_w[0] && act_i) |=> $stable(cnt_w)); // R4
            AST_BLOCK_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
                !act_ok_o |-> ($countones(hist_w) >= FAW_ACTS)); // R3
        end
    endgenerate
endmodule

// File: tb/faw_limiter_test.sv
module faw_limiter_test;
    localparam int unsigned W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act = 1'b0;
    logic ok;
    logic ok_off;

    always #5 clk = ~clk;

    faw_limiter #(.WINDOW(W)) uut (
        .clk(clk), .rst_n(rst_n), .act_i(act), .act_ok_o(ok));

    faw_limiter #(.WINDOW(0)) uut_off (
        .clk(clk), .rst_n(rst_n), .act_i(act), .act_ok_o(ok_off));

    typedef struct {
        bit    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb[$];
    int       act_times[$];
    int       cyc = 0;
    int       n_checks = 0;
    int       n_fail = 0;
    bit       done = 1'b0;

    task automatic check(input bit got, input bit exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: act_ok actual=%0b expected=%0b (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // driver: one clock edge per call, reference model pushes expected flag
    task automatic step(input bit a, input string tag);
        int cnt;
        sb_item_t it;
        @(negedge clk);
        act = a;
        @(posedge clk);
        if (a) act_times.push_back(cyc);
        while (act_times.size() > 0 && act_times[0] <= cyc - int'(W))
            void'(act_times.pop_front());
        cnt = act_times.size();
        it.exp = (cnt < 4);
        it.tag = tag;
        sb.push_back(it);
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            check(ok, it.exp, it.tag);
            check(ok_off, 1'b1, "R6");
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ok, 1'b1, "R1");
        check(ok_off, 1'b1, "R1");

        // R2: lone activate never closes the window
        step(1'b1, "R2");
        idle(W + 2, "R2");

        // R3: burst of four, flag low then reopens
        for (int i = 0; i < 4; i++) step(1'b1, "R3");
        idle(W + 2, "R3");

        // R4: new activate on the edge the oldest one leaves
        for (int i = 0; i < 4; i++) step(1'b1, "R4");
        idle(W - 4, "R4");
        step(1'b1, "R4");
        idle(W + 2, "R4");

        // R5: pulses while blocked still recorded
        for (int i = 0; i < 6; i++) step(1'b1, "R5");
        idle(W + 4, "R5");

        // R8: evenly spaced activates
        for (int i = 0; i < 12; i++) begin
            step(1'b1, "R8");
            idle(4, "R8");
        end
        for (int i = 0; i < 8; i++) begin
            step(1'b1, "R8");
            idle(2, "R8");
        end
        idle(W + 2, "R8");

        // R7: saturate the history, then drain
        for (int i = 0; i < int'(W) + 10; i++) step(1'b1, "R7");
        idle(W + 3, "R7");

        @(negedge clk);
        act = 1'b0;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule